// File: doc/BRIEF.md
# Terminal Character Port with Ready Flags and Interrupt Request

This block is the processor-facing side of a character terminal. On the device side it has one serial receive line, one serial transmit line and a bit-rate tick. On the processor side it has a character bus in each direction and one-cycle strobes for the four terminal instructions: take an input character, send an output character, enable interrupts and disable interrupts. A receive-ready flag and a transmit-ready flag let a slow device and a fast processor meet. The processor either polls them through the ready outputs or waits for the interrupt request.

A received character is held in an 8-bit input register and the receive-ready flag is raised. Taking the character clears that flag. A character handed over while the transmit-ready flag is set is latched into the output register, the flag drops, and the character leaves serially. The flag rises again once the frame is complete. The interrupt-enable flip-flop is kept here. The request it gates is held low while the processor reports a fetch step. The processor's acknowledge from its interrupt cycle clears the enable.

Top module: `term_io_port`

## Requirements
- R1: After reset, in_ready=0, out_ready=1, int_enable=0, rx_overrun=0, irq=0, ser_out=1 and rx_char=0.
- R2: A frame on ser_in is a 0 start bit, then 8 data bits with the least significant bit first, then a 1 stop bit. The line is sampled once per bit, in each cycle where bit_tick=1, and a start bit is taken only from the idle state. After a good stop bit, rx_char holds the character and in_ready=1 from the next cycle.
- R3: A frame whose stop bit samples as 0 is discarded: in_ready and rx_char are unchanged.
- R4: A good frame that ends while in_ready=1, with no inp_stb in the same cycle, is dropped. rx_char keeps the old character and rx_overrun becomes 1. An inp_stb clears rx_overrun.
- R5: inp_stb clears in_ready in the next cycle, unless a good frame ends in the same cycle. In that case the new character is taken and in_ready stays 1.
- R6: out_stb while out_ready=1 latches tx_char and out_ready is 0 from the next cycle. On each of the next ten ticks ser_out changes one cycle later: to the 0 start bit, then the 8 data bits with the least significant bit first, then the 1 stop bit. When not sending, ser_out is 1.
- R7: out_ready returns to 1 one cycle after the eleventh tick following the load, which ends the stop bit.
- R8: out_stb while out_ready=0 is ignored: the character being sent is unchanged and out_ready stays 0.
- R9: ion_stb sets int_enable. iof_stb and irq_ack each clear it, and a clear wins over a set in the same cycle.
- R10: irq = int_enable AND (in_ready OR out_ready) AND NOT fetch_step. It is combinational, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| ser_in | input | 1 | Serial receive line from the device |
| ser_out | output | 1 | Serial transmit line to the device |
| rx_char | output | 8 | Input register contents |
| tx_char | input | 8 | Character offered for transmission |
| inp_stb | input | 1 | Take-input strobe |
| out_stb | input | 1 | Send-output strobe |
| ion_stb | input | 1 | Interrupt-enable-on strobe |
| iof_stb | input | 1 | Interrupt-enable-off strobe |
| irq_ack | input | 1 | Interrupt cycle acknowledge |
| fetch_step | input | 1 | High during the processor's fetch/decode steps |
| in_ready | output | 1 | Receive-ready flag |
| out_ready | output | 1 | Transmit-ready flag |
| int_enable | output | 1 | Interrupt-enable flip-flop |
| rx_overrun | output | 1 | A character was lost because the input register was full |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a send-output strobe that lands while a frame is going out. Only the serial waveform can show that it had no effect. The bench therefore issues a second strobe with a different character part way through a transmission and keeps decoding the line bit by bit against the first character. Overrun needs two complete frames with no take-input strobe in between, so the bench sends one frame, leaves the flag set and then sends a second frame.

// File: rtl/term_io_pkg.sv
package term_io_pkg;
    localparam int CHAR_W  = 8;
    localparam int FRAME_W = CHAR_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_STOP} rx_state_e;

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [CHAR_W-1:0] shreg;
    } rx_regs_t;

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
        logic               line;
    } tx_regs_t;

    typedef struct packed {
        logic              fgi;
        logic              fgo;
        logic              ien;
        logic              ovr;
        logic [CHAR_W-1:0] inpr;
    } flag_regs_t;
endpackage

// File: rtl/term_rx.sv
module term_rx
    import term_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_in,
    output logic              frame_ok,
    output logic [CHAR_W-1:0] frame_data
);
    rx_regs_t rx_d, rx_q;

    always_comb begin
        rx_d     = rx_q;
        frame_ok = 1'b0;
        if (tick) begin
            case (rx_q.state)
                RX_IDLE: begin
                    if (!line_in) begin
                        rx_d.state = RX_DATA;
                        rx_d.cnt   = '0;
                    end
                end
                RX_DATA: begin
                    rx_d.shreg = {line_in, rx_q.shreg[CHAR_W-1:1]};
                    if (rx_q.cnt == CNT_W'(CHAR_W - 1))
                        rx_d.state = RX_STOP;
                    else
                        rx_d.cnt = rx_q.cnt + 1'b1;
                end
                RX_STOP: begin
                    rx_d.state = RX_IDLE;
                    frame_ok   = line_in;
                end
                default: rx_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q.state <= RX_IDLE;
            rx_q.cnt   <= '0;
            rx_q.shreg <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign frame_data = rx_q.shreg;

    // R2
    rx_back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> (rx_q.state == RX_IDLE));
endmodule

// File: rtl/term_tx.sv
module term_tx
    import term_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_data,
    output logic              line_out,
    output logic              done
);
    tx_regs_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        done = 1'b0;
        if (load && !tx_q.busy) begin
            tx_d.busy  = 1'b1;
            tx_d.cnt   = '0;
            tx_d.shreg = {1'b1, load_data, 1'b0};
        end else if (tx_q.busy && tick) begin
            if (tx_q.cnt == CNT_W'(FRAME_W)) begin
                tx_d.busy = 1'b0;
                done      = 1'b1;
            end else begin
                tx_d.line  = tx_q.shreg[0];
                tx_d.shreg = {1'b1, tx_q.shreg[FRAME_W-1:1]};
                tx_d.cnt   = tx_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q.busy  <= 1'b0;
            tx_q.cnt   <= '0;
            tx_q.shreg <= '1;
            tx_q.line  <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign line_out = tx_q.line;

    // R6
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_q.busy |-> line_out);
endmodule

// File: rtl/term_flags.sv
module term_flags
    import term_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inp_stb,
    input  logic              out_stb,
    input  logic              ion_stb,
    input  logic              iof_stb,
    input  logic              irq_ack,
    input  logic              frame_ok,
    input  logic [CHAR_W-1:0] frame_data,
    input  logic              tx_done,
    output logic              tx_load,
    output logic              fgi,
    output logic              fgo,
    output logic              ien,
    output logic              ovr,
    output logic [CHAR_W-1:0] inpr
);
    flag_regs_t fl_d, fl_q;

    always_comb begin
        fl_d    = fl_q;
        tx_load = out_stb && fl_q.fgo;
        if (tx_load) fl_d.fgo = 1'b0;
        if (tx_done) fl_d.fgo = 1'b1;
        if (inp_stb) begin
            fl_d.fgi = 1'b0;
            fl_d.ovr = 1'b0;
        end
        if (frame_ok) begin
            if (!fl_q.fgi || inp_stb) begin
                fl_d.inpr = frame_data;
                fl_d.fgi  = 1'b1;
            end else begin
                fl_d.ovr = 1'b1;
            end
        end
        if (ion_stb) fl_d.ien = 1'b1;
        if (iof_stb || irq_ack) fl_d.ien = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q.fgi  <= 1'b0;
            fl_q.fgo  <= 1'b1;
            fl_q.ien  <= 1'b0;
            fl_q.ovr  <= 1'b0;
            fl_q.inpr <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign fgi  = fl_q.fgi;
    assign fgo  = fl_q.fgo;
    assign ien  = fl_q.ien;
    assign ovr  = fl_q.ovr;
    assign inpr = fl_q.inpr;

    // R5
    inp_clears_fgi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inp_stb && !frame_ok) |=> !fgi);
    // R4
    ovr_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && fgi && !inp_stb) |=> (ovr && $stable(inpr)));
    // R8
    out_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_stb && !fgo && !tx_done) |=> !fgo);
    // R9
    ien_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iof_stb || irq_ack) |=> !ien);
endmodule

// File: rtl/term_io_port.sv
module term_io_port
    import term_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ser_in,
    output logic              ser_out,
    output logic [CHAR_W-1:0] rx_char,
    input  logic [CHAR_W-1:0] tx_char,
    input  logic              inp_stb,
    input  logic              out_stb,
    input  logic              ion_stb,
    input  logic              iof_stb,
    input  logic              irq_ack,
    input  logic              fetch_step,
    output logic              in_ready,
    output logic              out_ready,
    output logic              int_enable,
    output logic              rx_overrun,
    output logic              irq
);
    logic              frame_ok;
    logic [CHAR_W-1:0] frame_data;
    logic              tx_load;
    logic              tx_done;

    term_rx u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (bit_tick),
        .line_in    (ser_in),
        .frame_ok   (frame_ok),
        .frame_data (frame_data)
    );

    term_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (bit_tick),
        .load      (tx_load),
        .load_data (tx_char),
        .line_out  (ser_out),
        .done      (tx_done)
    );

    term_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .inp_stb    (inp_stb),
        .out_stb    (out_stb),
        .ion_stb    (ion_stb),
        .iof_stb    (iof_stb),
        .irq_ack    (irq_ack),
        .frame_ok   (frame_ok),
        .frame_data (frame_data),
        .tx_done    (tx_done),
        .tx_load    (tx_load),
        .fgi        (in_ready),
        .fgo        (out_ready),
        .ien        (int_enable),
        .ovr        (rx_overrun),
        .inpr       (rx_char)
    );

    assign irq = int_enable && (in_ready || out_ready) && !fetch_step;

    // R10
    irq_fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_step || !int_enable) |-> !irq);
endmodule

// File: tb/term_io_port_tb.sv
module term_io_port_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       ser_in = 1'b1;
    logic       ser_out;
    logic [7:0] rx_char;
    logic [7:0] tx_char = 8'h00;
    logic       inp_stb = 1'b0, out_stb = 1'b0, ion_stb = 1'b0, iof_stb = 1'b0;
    logic       irq_ack = 1'b0, fetch_step = 1'b0;
    logic       in_ready, out_ready, int_enable, rx_overrun, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    term_io_port u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ser_in(ser_in),
        .ser_out(ser_out), .rx_char(rx_char), .tx_char(tx_char),
        .inp_stb(inp_stb), .out_stb(out_stb), .ion_stb(ion_stb),
        .iof_stb(iof_stb), .irq_ack(irq_ack), .fetch_step(fetch_step),
        .in_ready(in_ready), .out_ready(out_ready), .int_enable(int_enable),
        .rx_overrun(rx_overrun), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        ser_in = b;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] c, input logic stop);
        tick_bit(1'b0);
        for (int i = 0; i < 8; i++) tick_bit(c[i]);
        tick_bit(stop);
        ser_in = 1'b1;
    endtask

    task automatic pulse_inp();
        inp_stb = 1'b1; @(negedge clk); inp_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 in_ready", 16'(in_ready), 16'h0);
        chk("R1 out_ready", 16'(out_ready), 16'h1);
        chk("R1 int_enable", 16'(int_enable), 16'h0);
        chk("R1 rx_overrun", 16'(rx_overrun), 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 ser_out", 16'(ser_out), 16'h1);
        chk("R1 rx_char", 16'(rx_char), 16'h0);
    endtask

    task automatic t_receive();
        send_frame(8'hA5, 1'b1);
        chk("R2 in_ready set", 16'(in_ready), 16'h1);
        chk("R2 rx_char", 16'(rx_char), 16'h00A5);
        pulse_inp();
        chk("R5 in_ready cleared", 16'(in_ready), 16'h0);
        chk("R5 rx_char kept", 16'(rx_char), 16'h00A5);
        send_frame(8'h01, 1'b1);
        chk("R2 lsb first", 16'(rx_char), 16'h0001);
        pulse_inp();
    endtask

    task automatic t_bad_stop();
        send_frame(8'h3C, 1'b0);
        chk("R3 in_ready unchanged", 16'(in_ready), 16'h0);
        chk("R3 rx_char unchanged", 16'(rx_char), 16'h0001);
    endtask

    task automatic t_overrun();
        send_frame(8'h5A, 1'b1);
        chk("R4 first accepted", 16'(rx_char), 16'h005A);
        chk("R4 no overrun yet", 16'(rx_overrun), 16'h0);
        send_frame(8'h11, 1'b1);
        chk("R4 rx_char kept", 16'(rx_char), 16'h005A);
        chk("R4 overrun set", 16'(rx_overrun), 16'h1);
        pulse_inp();
        chk("R4 overrun cleared", 16'(rx_overrun), 16'h0);
        chk("R5 in_ready cleared", 16'(in_ready), 16'h0);
    endtask

    task automatic t_transmit();
        logic [9:0] frame;
        frame = {1'b1, 8'hC3, 1'b0};
        tx_char = 8'hC3;
        out_stb = 1'b1; @(negedge clk); out_stb = 1'b0;
        chk("R6 out_ready cleared", 16'(out_ready), 16'h0);
        chk("R6 line idle before tick", 16'(ser_out), 16'h1);
        for (int k = 0; k < 10; k++) begin
            bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
            chk($sformatf("R6 bit %0d", k), 16'(ser_out), 16'(frame[k]));
            if (k == 4) begin
                tx_char = 8'hFF;
                out_stb = 1'b1; @(negedge clk); out_stb = 1'b0;
                chk("R8 out_ready stays 0", 16'(out_ready), 16'h0);
            end
            @(negedge clk);
        end
        chk("R7 not ready after stop start", 16'(out_ready), 16'h0);
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0;
        chk("R7 out_ready back", 16'(out_ready), 16'h1);
        chk("R6 line idle after", 16'(ser_out), 16'h1);
    endtask

    task automatic t_interrupt();
        chk("R10 no irq while disabled", 16'(irq), 16'h0);
        ion_stb = 1'b1; @(negedge clk); ion_stb = 1'b0;
        chk("R9 ion sets", 16'(int_enable), 16'h1);
        chk("R10 irq from out_ready", 16'(irq), 16'h1);
        fetch_step = 1'b1; #1;
        chk("R10 irq held off in fetch", 16'(irq), 16'h0);
        fetch_step = 1'b0; #1;
        chk("R10 irq back", 16'(irq), 16'h1);
        tx_char = 8'h00;
        out_stb = 1'b1; @(negedge clk); out_stb = 1'b0;
        chk("R10 no irq with no flag", 16'(irq), 16'h0);
        for (int k = 0; k < 11; k++) begin
            bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
        end
        chk("R10 irq on flag return", 16'(irq), 16'h1);
        ion_stb = 1'b1; iof_stb = 1'b1; @(negedge clk);
        ion_stb = 1'b0; iof_stb = 1'b0;
        chk("R9 clear wins", 16'(int_enable), 16'h0);
        ion_stb = 1'b1; @(negedge clk); ion_stb = 1'b0;
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        chk("R9 ack clears", 16'(int_enable), 16'h0);
        ion_stb = 1'b1; @(negedge clk); ion_stb = 1'b0;
        iof_stb = 1'b1; @(negedge clk); iof_stb = 1'b0;
        chk("R9 iof clears", 16'(int_enable), 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_receive();
        t_bad_stop();
        t_overrun();
        t_transmit();
        t_interrupt();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule